// File: doc/BRIEF.md
# Word-Wide Shift-Register Random Generator

This block is a pseudo-random number source built around a 33-bit linear feedback shift register. Its feedback is a single exclusive-OR of two taps. A caller raises a step request, and in one clock the register moves forward by thirty-two single-bit shifts. The thirty-two combinational stages are written out in full. The low thirty-two bits of the new state then appear as a fresh random word, and a valid flag is raised for one cycle.

Software or a neighbouring block sets the starting point through a seed load. The seed is a 32-bit word for the lower part of the register plus one extra bit for the top position. An all-zero state would freeze the register for ever, so a zero seed is replaced with a fixed nonzero constant. Reset installs a fixed nonzero default seed.

Top module: `prng_word_gen`

## Requirements
- R1: While and after synchronous reset, the state equals the default seed 33'h0_1D87_2B41, `rand_word` shows its low 32 bits (32'h1D87_2B41), and `rand_valid` is 0.
- R2: When `seed_load` is 1 and the seed is nonzero, the state becomes {`seed_top`, `seed_word`} at the next edge. `rand_word` then equals `seed_word` and `rand_valid` is 0.
- R3: When `seed_load` is 1 and both `seed_top` and `seed_word` are zero, the state becomes the constant 33'h1_5A5A_C3C3. `rand_word` then reads 32'h5A5A_C3C3.
- R4: A step request with no load advances the state by 32 serial steps. State bits are numbered 1 (LSB) to 33 (MSB). In each serial step, the new bit is bit 33 XOR bit 20, the state shifts left by one, and the new bit enters at bit 1. `rand_word` is bits 32..1 of the updated state.
- R5: `rand_valid` is 1 in exactly the cycle after an edge where `step_req` was 1 and `seed_load` was 0. In every other cycle it is 0, including during back-to-back step requests only in the sense that each accepted request yields a 1.
- R6: When `seed_load` and `step_req` are both 1 in the same cycle, the load wins. The state takes the seed without any shift, and `rand_valid` is 0.
- R7: With neither `seed_load` nor `step_req` asserted, the state and `rand_word` hold their values.
- R8: The state is never all zeros after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seed_load | input | 1 | Load the seed into the state |
| seed_word | input | 32 | Seed for state bits 32..1 |
| seed_top | input | 1 | Seed for state bit 33 |
| step_req | input | 1 | Advance by 32 serial steps |
| rand_word | output | 32 | State bits 32..1 |
| rand_valid | output | 1 | Fresh word from an accepted step |

## Verification
A seed load and a step request can arrive in the same cycle. The bench provokes this by raising both inputs together after the register has been run away from the seed. It judges the result by requiring that the next word equals the seed word unshifted and that the valid flag stays low. The bench then steps on and compares against its own model started from that seed. Zero-seed loads receive the same treatment, so the replacement constant is also proven to be the true starting point of the following sequence.

// File: rtl/prng_pkg.sv
package prng_pkg;
    localparam int STATE_W = 33;
    localparam int WORD_W  = 32;

    typedef struct packed {
        logic [STATE_W-1:0] state;
        logic               valid;
    } prng_regs_t;
endpackage

// File: rtl/prng_advance.sv
module prng_advance #(
    parameter int STATE_W = 33,
    parameter int TAP_HI  = 33,
    parameter int TAP_LO  = 20,
    parameter int STEPS   = 32
) (
    input  logic [STATE_W-1:0] cur,
    output logic [STATE_W-1:0] nxt
);
    logic [STATE_W-1:0] chain [STEPS+1];

    assign chain[0] = cur;

    // one stage per serial shift; taps are counted from 1
    for (genvar i = 0; i < STEPS; i++) begin : g_stage
        assign chain[i+1] = {chain[i][STATE_W-2:0],
                             chain[i][TAP_HI-1] ^ chain[i][TAP_LO-1]};
    end

    assign nxt = chain[STEPS];
endmodule

// File: rtl/prng_seed_guard.sv
module prng_seed_guard #(
    parameter int               STATE_W  = 33,
    parameter int               WORD_W   = 32,
    parameter logic [STATE_W-1:0] ZERO_FIX = 33'h1_5A5A_C3C3
) (
    input  logic [WORD_W-1:0]  seed_word,
    input  logic               seed_top,
    output logic [STATE_W-1:0] seed_eff
);
    localparam int PAD_W = STATE_W - WORD_W - 1;

    logic [STATE_W-1:0] raw;

    if (PAD_W > 0) begin : g_pad
        assign raw = {{PAD_W{1'b0}}, seed_top, seed_word};
    end else begin : g_nopad
        assign raw = {seed_top, seed_word};
    end

    always_comb begin
        seed_eff = raw;
        if (raw == '0) begin
            seed_eff = ZERO_FIX;
        end
    end
endmodule

// File: rtl/prng_word_gen.sv
module prng_word_gen
    import prng_pkg::*;
#(
    parameter int                 TAP_HI     = 33,
    parameter int                 TAP_LO     = 20,
    parameter int                 STEPS      = 32,
    parameter logic [STATE_W-1:0] RESET_SEED = 33'h0_1D87_2B41,
    parameter logic [STATE_W-1:0] ZERO_FIX   = 33'h1_5A5A_C3C3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_load,
    input  logic [WORD_W-1:0] seed_word,
    input  logic              seed_top,
    input  logic              step_req,
    output logic [WORD_W-1:0] rand_word,
    output logic              rand_valid
);
    prng_regs_t r_q, r_d;

    logic [STATE_W-1:0] adv_state;
    logic [STATE_W-1:0] seed_state;

    prng_advance #(
        .STATE_W(STATE_W),
        .TAP_HI (TAP_HI),
        .TAP_LO (TAP_LO),
        .STEPS  (STEPS)
    ) u_adv (
        .cur(r_q.state),
        .nxt(adv_state)
    );

    prng_seed_guard #(
        .STATE_W (STATE_W),
        .WORD_W  (WORD_W),
        .ZERO_FIX(ZERO_FIX)
    ) u_guard (
        .seed_word(seed_word),
        .seed_top (seed_top),
        .seed_eff (seed_state)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (seed_load) begin
            r_d.state = seed_state;
        end else if (step_req) begin
            r_d.state = adv_state;
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= RESET_SEED;
            r_q.valid <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rand_word  = r_q.state[WORD_W-1:0];
    assign rand_valid = r_q.valid;

    // R2: a nonzero seed appears unshifted on the output word
    a_r2_seed_visible: assert property (@(posedge clk) disable iff (rst)
        (seed_load && ({seed_top, seed_word} != '0)) |=> (rand_word == $past(seed_word)));

    // R3: a zero seed is replaced by the fixed constant
    a_r3_zero_fixed: assert property (@(posedge clk) disable iff (rst)
        (seed_load && ({seed_top, seed_word} == '0)) |=> (r_q.state == ZERO_FIX));

    // R4: an accepted step always moves the state
    a_r4_step_moves: assert property (@(posedge clk) disable iff (rst)
        (step_req && !seed_load) |=> (r_q.state != $past(r_q.state)));

    // R5: valid follows each accepted step
    a_r5_valid_after_step: assert property (@(posedge clk) disable iff (rst)
        (step_req && !seed_load) |=> rand_valid);

    // R5 and R6: no valid without an accepted step
    a_r6_valid_low_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(step_req && !seed_load) |=> !rand_valid);

    // R7: idle cycles hold the state
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_req && !seed_load) |=> $stable(r_q.state));

    // R8: the register never locks up at zero
    a_r8_nonzero: assert property (@(posedge clk) disable iff (rst)
        r_q.state != '0);
endmodule

// File: tb/prng_word_gen_test.sv
module prng_word_gen_test;
    localparam logic [32:0] DEF_SEED = 33'h0_1D87_2B41;
    localparam logic [32:0] FIX_SEED = 33'h1_5A5A_C3C3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seed_load = 1'b0;
    logic [31:0] seed_word = '0;
    logic        seed_top = 1'b0;
    logic        step_req = 1'b0;
    logic [31:0] rand_word;
    logic        rand_valid;

    int checks = 0;
    int errors = 0;
    logic [32:0] model;
    bit done = 0;

    always #4 clk = ~clk;

    prng_word_gen uut (
        .clk(clk), .rst(rst), .seed_load(seed_load), .seed_word(seed_word),
        .seed_top(seed_top), .step_req(step_req),
        .rand_word(rand_word), .rand_valid(rand_valid)
    );

    // bit-serial reference: 32 single shifts, bit 33 xor bit 20
    function automatic logic [32:0] ref_adv(input logic [32:0] s);
        logic [32:0] t = s;
        for (int k = 0; k < 32; k++) begin
            t = {t[31:0], t[32] ^ t[19]};
        end
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] w_exp, input logic v_exp);
        checks++;
        if (rand_word !== w_exp || rand_valid !== v_exp) begin
            errors++;
            $display("FAIL %s: word=%h valid=%b expected word=%h valid=%b",
                     req, rand_word, rand_valid, w_exp, v_exp);
        end
    endtask

    task automatic cyc(input logic ld, input logic st, input logic [32:0] sd);
        seed_load = ld; step_req = st;
        seed_word = sd[31:0]; seed_top = sd[32];
        @(posedge clk);
        @(negedge clk);
        seed_load = 1'b0; step_req = 1'b0;
    endtask

    task automatic load(input logic [32:0] sd, input string req);
        cyc(1'b1, 1'b0, sd);
        model = (sd == '0) ? FIX_SEED : sd;
        check(req, model[31:0], 1'b0);
    endtask

    task automatic step(input string req);
        cyc(1'b0, 1'b1, '0);
        model = ref_adv(model);
        check(req, model[31:0], 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 during reset", DEF_SEED[31:0], 1'b0);
        rst = 1'b0;
        @(negedge clk);
        model = DEF_SEED;
        check("R1 after reset", DEF_SEED[31:0], 1'b0);
        for (int n = 0; n < 4; n++) step("R4 from reset seed");

        // single-bit seeds over all 33 positions
        for (int p = 0; p < 33; p++) begin
            load(33'h1 << p, "R2 one-hot seed");
            for (int n = 0; n < 3; n++) step("R4 one-hot run");
        end
        // dense patterns including the top bit
        load(33'h1_FFFF_FFFF, "R2 all ones");
        for (int n = 0; n < 5; n++) step("R4 all ones run");
        load(33'h0_AAAA_5555, "R2 pattern");
        for (int n = 0; n < 5; n++) step("R4 pattern run");
        load(33'h1_0000_0000, "R2 top bit only");
        for (int n = 0; n < 5; n++) step("R4 top bit run");

        // zero seed lockup guard
        load('0, "R3 zero seed");
        for (int n = 0; n < 6; n++) step("R8 run after zero seed");

        // idle holds and drops valid
        cyc(1'b0, 1'b0, 33'h1_2345_6789);
        check("R7 idle one", model[31:0], 1'b0);
        cyc(1'b0, 1'b0, '0);
        check("R5 idle two", model[31:0], 1'b0);

        // load and step in one cycle
        step("R4 before collision");
        cyc(1'b1, 1'b1, 33'h0_C0DE_F00D);
        model = 33'h0_C0DE_F00D;
        check("R6 load beats step", model[31:0], 1'b0);
        step("R6 run after collision");
        cyc(1'b1, 1'b1, '0);
        model = FIX_SEED;
        check("R6 zero load beats step", model[31:0], 1'b0);
        step("R3 run after zero collision");

        // long back-to-back run
        load(33'h0_0000_0001, "R2 long run seed");
        for (int n = 0; n < 3000; n++) step("R5 back-to-back");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule